// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single memory reservation of one hart for word-sized load-reserved (LR) and store-conditional (SC) operations. Decoded requests come in on a command port, one per cycle. Each request gives an operation select, a byte address, store data and a destination register index. The block drives a single-ported synchronous memory. An LR reads the addressed word and returns it sign-extended to the register width. An SC writes memory only while a live reservation covers the stored word. Either way, the SC consumes the reservation. The SC result is 0 for success and 1 for failure.

The reservation granule is one naturally aligned 8-byte block. It is held as a valid bit plus the granule address tag. A snoop port reports stores by other agents as granule addresses. A snooped store that lands on the reserved granule kills the reservation. Each reservation also carries a reservability attribute, taken from a parameterised address window. The attribute is eventual outside the window and non-eventual inside it. Software can read it to tell when forward progress is not guaranteed and fall back to another sequence. A misaligned request raises an error pulse, touches no memory and drops the reservation.

Top module: `lrsc_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsv_valid`, `wb_valid`, `wb_err` and `mem_en` are 0.
- R2: An aligned LR (`cmd_is_sc`=0, `cmd_addr[1:0]`=0) drives a memory read of `cmd_addr` in the same cycle. In the next cycle `wb_valid`=1, `wb_rd` equals the request's `cmd_rd`, and `wb_data` holds the word with bit 31 copied into all upper bits.
- R3: An aligned LR sets `rsv_valid` to 1 on the granule `cmd_addr[AW-1:3]`, even if a snoop hits that granule in the same cycle. `rsv_eventual` becomes 0 when `NE_BASE <= cmd_addr < NE_LIMIT`, and 1 otherwise.
- R4: An aligned SC (`cmd_is_sc`=1) whose granule matches a valid reservation drives `mem_en`=`mem_we`=1 with `cmd_wdata` in the same cycle. Its result in the next cycle is `wb_data`=0.
- R5: An SC that finds no valid reservation, or a reservation on another granule, leaves `mem_en` at 0. Its result is `wb_data`=1.
- R6: After any SC, whether it succeeds, fails or is misaligned, `rsv_valid` is 0 in the next cycle.
- R7: A snoop whose `snoop_tag` equals the reserved granule clears `rsv_valid` at the next edge. A snoop to any other granule leaves the reservation in place.
- R8: An SC that arrives in the same cycle as a snoop to its own granule fails. It does not write memory and returns 1.
- R9: A request with `cmd_addr[1:0]` not equal to 0 gives `mem_en`=0 in that cycle. In the next cycle it gives `wb_err`=1 with `wb_valid`=0, and it clears the reservation.
- R10: A new LR replaces any earlier reservation, so an SC to the earlier granule then fails.
- R11: An SC to a different word of the same 8-byte granule as the LR succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present this cycle |
| cmd_is_sc | input | 1 | 0 = LR, 1 = SC |
| cmd_addr | input | AW | Byte address of the word |
| cmd_wdata | input | 32 | Store data for SC |
| cmd_rd | input | 5 | Destination register index |
| snoop_valid | input | 1 | Another agent stores this cycle |
| snoop_tag | input | AW-3 | Granule address of that store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| wb_valid | output | 1 | Register writeback valid |
| wb_err | output | 1 | Misaligned-request error pulse |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | XLEN | Writeback value |
| rsv_valid | output | 1 | Reservation live |
| rsv_eventual | output | 1 | Reservability of the reserved granule |

## Verification
The memory strobes follow a request in the same cycle. The bench checks them one time unit after it drives the request, while the inputs are still held. Every writeback and error pulse appears exactly one edge after the request is taken. The driver therefore pushes the expected result into a queue when it issues the request, and the monitor pops and compares at the falling edge that follows. Reservation state is also visible one edge later, so the driver reads `rsv_valid` and `rsv_eventual` at that same falling edge, before it issues the next request.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   localparam int RD_W      = 5;
   localparam int WORD_BITS = 32;

   typedef enum logic {
      OP_LR = 1'b0,
      OP_SC = 1'b1
   } lrsc_op_e;

   typedef struct packed {
      logic            vld;
      logic            err;
      lrsc_op_e        op;
      logic            sc_ok;
      logic [RD_W-1:0] rd;
   } lrsc_stage_t;
endpackage

// File: rtl/lrsc_region_attr.sv
module lrsc_region_attr #(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] NE_BASE  = '0,
   parameter logic [AW-1:0] NE_LIMIT = '0
) (
   input  logic [AW-1:0] addr,
   output logic          eventual
);
   generate
      if (NE_LIMIT > NE_BASE) begin : g_window
         always_comb eventual = !((addr >= NE_BASE) && (addr < NE_LIMIT));
      end else begin : g_all_eventual
         always_comb eventual = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lrsc_granule_rsv.sv
module lrsc_granule_rsv #(
   parameter int TAG_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [TAG_W-1:0] set_tag,
   input  logic             set_evt,
   input  logic             clr_en,
   input  logic             snoop_valid,
   input  logic [TAG_W-1:0] snoop_tag,
   output logic             valid,
   output logic [TAG_W-1:0] tag,
   output logic             eventual
);
   logic snoop_kill;

   always_comb snoop_kill = snoop_valid && valid && (snoop_tag == tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         tag      <= '0;
         eventual <= 1'b1;
      end else if (set_en) begin
         valid    <= 1'b1;
         tag      <= set_tag;
         eventual <= set_evt;
      end else if (clr_en || snoop_kill) begin
         valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/lrsc_wb_fmt.sv
module lrsc_wb_fmt
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  lrsc_stage_t          stg,
   input  logic [WORD_BITS-1:0] mem_rdata,
   output logic                 wb_valid,
   output logic                 wb_err,
   output logic [RD_W-1:0]      wb_rd,
   output logic [XLEN-1:0]      wb_data
);
   localparam logic [XLEN-1:0] SC_PASS = '0;
   localparam logic [XLEN-1:0] SC_FAIL = {{(XLEN-1){1'b0}}, 1'b1};

   logic [XLEN-1:0] load_ext;

   generate
      if (XLEN == WORD_BITS) begin : g_no_ext
         always_comb load_ext = mem_rdata;
      end else begin : g_sext
         always_comb load_ext = {{(XLEN-WORD_BITS){mem_rdata[WORD_BITS-1]}}, mem_rdata};
      end
   endgenerate

   always_comb begin
      wb_valid = stg.vld && !stg.err;
      wb_err   = stg.vld && stg.err;
      wb_rd    = stg.rd;
      if (stg.op == OP_SC) wb_data = stg.sc_ok ? SC_PASS : SC_FAIL;
      else                 wb_data = load_ext;
   end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
   import lrsc_pkg::*;
#(
   parameter int            AW            = 32,
   parameter int            XLEN          = 64,
   parameter int            GRANULE_BYTES = 8,
   parameter logic [AW-1:0] NE_BASE       = '0,
   parameter logic [AW-1:0] NE_LIMIT      = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_is_sc,
   input  logic [AW-1:0]         cmd_addr,
   input  logic [WORD_BITS-1:0]  cmd_wdata,
   input  logic [RD_W-1:0]       cmd_rd,
   input  logic                  snoop_valid,
   input  logic [AW-$clog2(GRANULE_BYTES)-1:0] snoop_tag,
   output logic                  mem_en,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [WORD_BITS-1:0]  mem_wdata,
   input  logic [WORD_BITS-1:0]  mem_rdata,
   output logic                  wb_valid,
   output logic                  wb_err,
   output logic [RD_W-1:0]       wb_rd,
   output logic [XLEN-1:0]       wb_data,
   output logic                  rsv_valid,
   output logic                  rsv_eventual
);
   localparam int GB    = $clog2(GRANULE_BYTES);
   localparam int TAG_W = AW - GB;

   generate
      if (XLEN < WORD_BITS) begin : g_bad_xlen
         $error("XLEN must be at least the word width");
      end
      if ((GRANULE_BYTES < 4) || ((1 << GB) != GRANULE_BYTES)) begin : g_bad_gran
         $error("GRANULE_BYTES must be a power of two of at least 4");
      end
      if (AW <= GB) begin : g_bad_aw
         $error("AW must exceed the granule offset width");
      end
   endgenerate

   logic             aligned;
   logic             do_lr;
   logic             do_sc;
   logic             misal;
   logic [TAG_W-1:0] cmd_tag;
   logic             snoop_same;
   logic             sc_ok;
   logic             cmd_evt;
   logic [TAG_W-1:0] rsv_tag;
   lrsc_stage_t      stg_q;

   always_comb begin
      aligned    = (cmd_addr[1:0] == 2'b00);
      cmd_tag    = cmd_addr[AW-1:GB];
      do_lr      = cmd_valid && aligned && (lrsc_op_e'(cmd_is_sc) == OP_LR);
      do_sc      = cmd_valid && aligned && (lrsc_op_e'(cmd_is_sc) == OP_SC);
      misal      = cmd_valid && !aligned;
      snoop_same = snoop_valid && (snoop_tag == cmd_tag);
      sc_ok      = do_sc && rsv_valid && (rsv_tag == cmd_tag) && !snoop_same;
      mem_en     = do_lr || sc_ok;
      mem_we     = sc_ok;
      mem_addr   = cmd_addr;
      mem_wdata  = cmd_wdata;
   end

   lrsc_region_attr #(
      .AW(AW), .NE_BASE(NE_BASE), .NE_LIMIT(NE_LIMIT)
   ) u_attr (
      .addr(cmd_addr), .eventual(cmd_evt)
   );

   lrsc_granule_rsv #(.TAG_W(TAG_W)) u_rsv (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (do_lr),
      .set_tag    (cmd_tag),
      .set_evt    (cmd_evt),
      .clr_en     (do_sc || misal),
      .snoop_valid(snoop_valid),
      .snoop_tag  (snoop_tag),
      .valid      (rsv_valid),
      .tag        (rsv_tag),
      .eventual   (rsv_eventual)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q.vld   <= cmd_valid;
         stg_q.err   <= misal;
         stg_q.op    <= lrsc_op_e'(cmd_is_sc);
         stg_q.sc_ok <= sc_ok;
         stg_q.rd    <= cmd_rd;
      end
   end

   lrsc_wb_fmt #(.XLEN(XLEN)) u_wb (
      .stg      (stg_q),
      .mem_rdata(mem_rdata),
      .wb_valid (wb_valid),
      .wb_err   (wb_err),
      .wb_rd    (wb_rd),
      .wb_data  (wb_data)
   );
endmodule

module lrsc_monitor_chk #(
   parameter int AW    = 32,
   parameter int TAG_W = 29
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_is_sc,
   input logic [AW-1:0]    cmd_addr,
   input logic [4:0]       cmd_rd,
   input logic             snoop_valid,
   input logic [TAG_W-1:0] snoop_tag,
   input logic             mem_en,
   input logic             mem_we,
   input logic             wb_valid,
   input logic             wb_err,
   input logic [4:0]       wb_rd,
   input logic             rsv_valid,
   input logic [TAG_W-1:0] rsv_tag
);
   localparam int GB = AW - TAG_W;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> !rsv_valid && !wb_valid && !wb_err);

   assert_lr_writeback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_is_sc && (cmd_addr[1:0] == 2'b00)
      |=> wb_valid && (wb_rd == $past(cmd_rd)));

   assert_write_needs_rsv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> cmd_valid && cmd_is_sc && rsv_valid && (cmd_addr[AW-1:GB] == rsv_tag));

   assert_sc_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_is_sc |=> !rsv_valid);

   assert_snoop_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid && rsv_valid && (snoop_tag == rsv_tag)
      && !(cmd_valid && !cmd_is_sc && (cmd_addr[1:0] == 2'b00))
      |=> !rsv_valid);

   assert_snoop_sc_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_is_sc && snoop_valid && (snoop_tag == cmd_addr[AW-1:GB])
      |-> !mem_we);

   assert_misalign_no_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_addr[1:0] != 2'b00) |-> !mem_en);

   assert_misalign_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_addr[1:0] != 2'b00) |=> wb_err && !wb_valid && !rsv_valid);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.AW(AW), .TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_is_sc  (cmd_is_sc),
   .cmd_addr   (cmd_addr),
   .cmd_rd     (cmd_rd),
   .snoop_valid(snoop_valid),
   .snoop_tag  (snoop_tag),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .wb_valid   (wb_valid),
   .wb_err     (wb_err),
   .wb_rd      (wb_rd),
   .rsv_valid  (rsv_valid),
   .rsv_tag    (rsv_tag)
);

// File: tb/sim_lrsc_monitor.sv
`timescale 1ns/1ps
module sim_lrsc_monitor;
   localparam int AW = 32;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0, cmd_is_sc = 1'b0;
   logic [AW-1:0]   cmd_addr = '0;
   logic [31:0]     cmd_wdata = '0;
   logic [4:0]      cmd_rd = '0;
   logic            snoop_valid = 1'b0;
   logic [AW-4:0]   snoop_tag = '0;
   logic            mem_en, mem_we;
   logic [AW-1:0]   mem_addr;
   logic [31:0]     mem_wdata;
   logic [31:0]     mem_rdata = '0;
   logic            wb_valid, wb_err, rsv_valid, rsv_eventual;
   logic [4:0]      wb_rd;
   logic [XLEN-1:0] wb_data;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] ram    [32];
   logic [31:0] shadow [32];

   logic        q_err  [$];
   logic [4:0]  q_rd   [$];
   logic [63:0] q_data [$];
   string       q_req  [$];

   always #10 clk = ~clk;

   lrsc_monitor #(
      .AW(AW), .XLEN(XLEN), .GRANULE_BYTES(8),
      .NE_BASE(32'h40), .NE_LIMIT(32'h80)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_is_sc(cmd_is_sc), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cmd_rd(cmd_rd),
      .snoop_valid(snoop_valid), .snoop_tag(snoop_tag),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .wb_valid(wb_valid), .wb_err(wb_err), .wb_rd(wb_rd), .wb_data(wb_data),
      .rsv_valid(rsv_valid), .rsv_eventual(rsv_eventual)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr[6:2]] <= mem_wdata;
         else        mem_rdata <= ram[mem_addr[6:2]];
      end
   end

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: results are due one edge after the request
   always @(negedge clk) begin
      if (rst_n && (wb_valid || wb_err)) begin
         if (q_err.size() == 0) begin
            check(1'b0, "unexpected result", {63'd0, wb_valid}, 64'd0);
         end else begin
            logic       e_err;
            logic [4:0] e_rd;
            logic [63:0] e_dat;
            string      e_req;
            e_err = q_err.pop_front();
            e_rd  = q_rd.pop_front();
            e_dat = q_data.pop_front();
            e_req = q_req.pop_front();
            check(wb_err == e_err && wb_valid == !e_err, {e_req, " kind"},
                  {62'd0, wb_err, wb_valid}, {62'd0, e_err, !e_err});
            check(wb_rd == e_rd, {e_req, " rd"}, {59'd0, wb_rd}, {59'd0, e_rd});
            if (!e_err) check(wb_data == e_dat, {e_req, " data"}, wb_data, e_dat);
         end
      end
   end

   // driver: call just after a falling edge
   task automatic issue(input logic sc, input logic [31:0] a, input logic [31:0] wd,
                        input logic [4:0] rd, input logic snp, input logic [31:0] sa,
                        input logic exp_ok, input logic exp_rsv, input string req);
      logic mis;
      logic exp_en;
      logic [31:0] w;
      mis    = (a[1:0] != 2'b00);
      exp_en = !mis && (!sc || exp_ok);
      w      = shadow[a[6:2]];
      cmd_valid = 1'b1; cmd_is_sc = sc; cmd_addr = a; cmd_wdata = wd; cmd_rd = rd;
      snoop_valid = snp; snoop_tag = sa[AW-1:3];
      q_err.push_back(mis);
      q_rd.push_back(rd);
      q_data.push_back(sc ? (exp_ok ? 64'd0 : 64'd1) : {{32{w[31]}}, w});
      q_req.push_back(req);
      #1;
      check(mem_en == exp_en && mem_we == (exp_en && sc), {req, " mem strobe"},
            {62'd0, mem_en, mem_we}, {62'd0, exp_en, exp_en && sc});
      @(posedge clk);
      if (sc && exp_ok) shadow[a[6:2]] = wd;
      @(negedge clk);
      cmd_valid = 1'b0; snoop_valid = 1'b0;
      check(rsv_valid == exp_rsv, {req, " rsv_valid"}, {63'd0, rsv_valid}, {63'd0, exp_rsv});
   endtask

   task automatic idle_snoop(input logic [31:0] sa, input logic exp_rsv, input string req);
      snoop_valid = 1'b1; snoop_tag = sa[AW-1:3];
      @(negedge clk);
      snoop_valid = 1'b0;
      check(rsv_valid == exp_rsv, req, {63'd0, rsv_valid}, {63'd0, exp_rsv});
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin
         ram[i]    = (i % 2 == 0) ? (32'h8000_1000 + i) : (32'h0123_4000 + i);
         shadow[i] = ram[i];
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!rsv_valid && !wb_valid && !wb_err && !mem_en, "R1 reset",
            {60'd0, rsv_valid, wb_valid, wb_err, mem_en}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rsv_valid && !wb_valid, "R1 after reset", {62'd0, rsv_valid, wb_valid}, 64'd0);

      // R2/R3 LR with negative word, eventual region
      issue(1'b0, 32'h10, 0, 5'd3, 1'b0, 0, 1'b0, 1'b1, "R2 R3 LR 0x10");
      check(rsv_eventual == 1'b1, "R3 eventual", {63'd0, rsv_eventual}, 64'd1);
      // R11/R4/R6 SC to other word of same granule
      issue(1'b1, 32'h14, 32'h7654_3210, 5'd4, 1'b0, 0, 1'b1, 1'b0, "R4 R11 R6 SC ok");
      // R5 SC with no reservation
      issue(1'b1, 32'h10, 32'hDEAD_BEEF, 5'd5, 1'b0, 0, 1'b0, 1'b0, "R5 SC no rsv");
      // R2 positive sign extension, confirms write
      issue(1'b0, 32'h14, 0, 5'd6, 1'b0, 0, 1'b0, 1'b1, "R2 R4 LR readback");
      issue(1'b0, 32'h10, 0, 5'd7, 1'b0, 0, 1'b0, 1'b1, "R5 R2 LR unchanged");
      // R5 SC to other granule
      issue(1'b0, 32'h20, 0, 5'd8, 1'b0, 0, 1'b0, 1'b1, "R2 LR 0x20");
      issue(1'b1, 32'h28, 32'h1111_1111, 5'd9, 1'b0, 0, 1'b0, 1'b0, "R5 R6 SC other granule");
      // R7 snoops
      issue(1'b0, 32'h20, 0, 5'd10, 1'b0, 0, 1'b0, 1'b1, "R2 LR 0x20 again");
      idle_snoop(32'h30, 1'b1, "R7 snoop other granule keeps");
      idle_snoop(32'h24, 1'b0, "R7 snoop same granule kills");
      issue(1'b1, 32'h20, 32'h2222_2222, 5'd11, 1'b0, 0, 1'b0, 1'b0, "R7 SC after snoop");
      // R8 same-cycle snoop
      issue(1'b0, 32'h20, 0, 5'd12, 1'b0, 0, 1'b0, 1'b1, "R2 LR 0x20 third");
      issue(1'b1, 32'h20, 32'h3333_3333, 5'd13, 1'b1, 32'h24, 1'b0, 1'b0, "R8 SC snoop race");
      // R3 non-eventual region
      issue(1'b0, 32'h44, 0, 5'd14, 1'b0, 0, 1'b0, 1'b1, "R3 LR 0x44");
      check(rsv_eventual == 1'b0, "R3 non-eventual", {63'd0, rsv_eventual}, 64'd0);
      // R10 replacement
      issue(1'b0, 32'h08, 0, 5'd15, 1'b0, 0, 1'b0, 1'b1, "R10 LR 0x08");
      check(rsv_eventual == 1'b1, "R3 back to eventual", {63'd0, rsv_eventual}, 64'd1);
      issue(1'b0, 32'h30, 0, 5'd16, 1'b0, 0, 1'b0, 1'b1, "R10 LR 0x30");
      issue(1'b1, 32'h08, 32'h4444_4444, 5'd17, 1'b0, 0, 1'b0, 1'b0, "R10 SC old granule");
      issue(1'b0, 32'h30, 0, 5'd18, 1'b0, 0, 1'b0, 1'b1, "R10 LR 0x30 again");
      issue(1'b1, 32'h30, 32'h8765_4321, 5'd19, 1'b0, 0, 1'b1, 1'b0, "R4 SC 0x30 ok");
      // R9 misaligned
      issue(1'b0, 32'h10, 0, 5'd20, 1'b0, 0, 1'b0, 1'b1, "R2 LR 0x10 before misalign");
      issue(1'b1, 32'h12, 32'h5555_5555, 5'd21, 1'b0, 0, 1'b0, 1'b0, "R9 misaligned SC");
      issue(1'b0, 32'h06, 0, 5'd22, 1'b0, 0, 1'b0, 1'b0, "R9 misaligned LR");
      // final readbacks: failed SCs wrote nothing
      issue(1'b0, 32'h20, 0, 5'd23, 1'b0, 0, 1'b0, 1'b1, "R8 R7 LR 0x20 unchanged");
      issue(1'b0, 32'h28, 0, 5'd24, 1'b0, 0, 1'b0, 1'b1, "R5 LR 0x28 unchanged");
      issue(1'b0, 32'h30, 0, 5'd25, 1'b0, 0, 1'b0, 1'b1, "R4 LR 0x30 written");
      issue(1'b0, 32'h08, 0, 5'd26, 1'b0, 0, 1'b0, 1'b1, "R10 LR 0x08 unchanged");
      @(negedge clk);
      check(q_err.size() == 0, "all results seen", q_err.size(), 64'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule